// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block owns a small word-addressed memory and serves one request at a time from a single requester. Each request names an operation, a word address and up to two operand values. The operations are plain load, plain store, and four atomic read-modify-write operations: test-and-set, swap, fetch-and-add and compare-and-swap. Each request gets one response. The response carries the word that was read. For compare-and-swap it also carries a success flag. For an unknown operation code it carries an error flag.

The memory has a read latency of one cycle. An atomic operation therefore reads the word in one cycle and writes it back in the next. The request side stays closed for the whole of that window. No other access can fall between the read and the write. Plain loads and stores use the same single memory port and need one memory cycle each.

The control is a three-state machine:
- `ST_IDLE` accepts a request.
- `ST_MODIFY` holds the read data and performs the conditional write-back.
- `ST_RESP` presents the response for one cycle.

The transitions are:
- IDLE to RESP (accept of a load, store or bad code)
- IDLE to MODIFY (accept of an atomic)
- MODIFY to RESP (write-back done)
- RESP to IDLE (response delivered)

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` is 0.
- R2: Operation code 0 (load) returns the addressed word. Code 1 (store) writes `req_opa` and returns data 0. Both raise `rsp_valid` in the first cycle after the accepting clock edge.
- R3: Code 2 (test-and-set) returns the old word. It writes 1 only when the old word was 0, and leaves the word unchanged otherwise.
- R4: Code 3 (swap) returns the old word and writes `req_opa`.
- R5: Code 4 (fetch-and-add) returns the old word and writes old + `req_opa` modulo 2^DATA_W. No overflow indication is produced.
- R6: Code 5 (compare-and-swap) compares the word with `req_opa`. On equality it writes `req_opb` and sets `rsp_status`. On inequality it leaves memory unchanged and clears `rsp_status`. It returns the old word in both cases.
- R7: An atomic response appears in the second cycle after the accepting edge, and `req_ready` is 0 in both cycles between acceptance and the response.
- R8: Codes 6 and 7 produce a response with `rsp_err`=1 and data 0, and do not modify memory.
- R9: `rsp_status` is 1 only on a successful compare-and-swap response. `rsp_err` is 1 only on an error response.
- R10: One request is in flight at a time. `req_ready` is 0 while `rsp_valid` is 1 and returns to 1 in the next cycle, so successive atomics on one word act in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Word address |
| req_opa | input | DATA_W | Store data, swap value, addend or compare value |
| req_opb | input | DATA_W | New value for compare-and-swap |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_data | output | DATA_W | Word read, or 0 for store and error |
| rsp_status | output | 1 | Compare-and-swap succeeded |
| rsp_err | output | 1 | Operation code was invalid |

## Verification
The assertions assume that `req_op` and `req_valid` carry known values from reset onward. They also assume that the requester treats a request as taken only on a cycle where `req_valid` and `req_ready` are both high. The stimulus drives every input at time zero and changes it only on falling edges. It raises `req_valid` for exactly one cycle while the unit is idle, and waits for the response before issuing the next request. Every address in range is a legal word address, because the depth is a power of two.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
    localparam logic [2:0] OP_LOAD  = 3'd0;
    localparam logic [2:0] OP_STORE = 3'd1;
    localparam logic [2:0] OP_TAS   = 3'd2;
    localparam logic [2:0] OP_SWAP  = 3'd3;
    localparam logic [2:0] OP_FADD  = 3'd4;
    localparam logic [2:0] OP_CAS   = 3'd5;

    typedef enum logic [1:0] {
        CLS_LOAD,
        CLS_STORE,
        CLS_ATOMIC,
        CLS_BAD
    } op_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MODIFY,
        ST_RESP
    } rmw_state_e;
endpackage

// File: rtl/rmw_decode.sv
module rmw_decode
    import rmw_pkg::*;
(
    input  logic [2:0] op,
    output op_class_e  cls
);
    always_comb begin
        unique case (op)
            OP_LOAD:                           cls = CLS_LOAD;
            OP_STORE:                          cls = CLS_STORE;
            OP_TAS, OP_SWAP, OP_FADD, OP_CAS:  cls = CLS_ATOMIC;
            default:                           cls = CLS_BAD;
        endcase
    end
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
    import rmw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] new_word,
    output logic              wr_en,
    output logic              cas_ok
);
    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
    localparam logic [DATA_W-1:0] ZERO = '0;

    always_comb begin
        new_word = old_word;
        wr_en    = 1'b0;
        cas_ok   = 1'b0;
        unique case (op)
            OP_TAS: begin
                new_word = ONE;
                wr_en    = (old_word == ZERO);
            end
            OP_SWAP: begin
                new_word = opa;
                wr_en    = 1'b1;
            end
            OP_FADD: begin
                new_word = old_word + opa;
                wr_en    = 1'b1;
            end
            OP_CAS: begin
                new_word = opb;
                cas_ok   = (old_word == opa);
                wr_en    = cas_ok;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rmw_mem.sv
module rmw_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                store_q[addr] <= wdata;
            end else begin
                rdata <= store_q[addr];
            end
        end
    end
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import rmw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_opa,
    input  logic [DATA_W-1:0] req_opb,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_status,
    output logic              rsp_err
);
    rmw_state_e        state_q, state_d;
    op_class_e         req_cls;
    logic              accept;

    logic [2:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] opa_q, opb_q, result_q;
    logic              status_q, err_q;

    logic              mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    logic [DATA_W-1:0] alu_word;
    logic              alu_we, alu_cas_ok;

    rmw_decode u_decode (
        .op  (req_op),
        .cls (req_cls)
    );

    rmw_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (op_q),
        .old_word (mem_rdata),
        .opa      (opa_q),
        .opb      (opb_q),
        .new_word (alu_word),
        .wr_en    (alu_we),
        .cas_ok   (alu_cas_ok)
    );

    rmw_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    // Single memory port: the request drives it on accept, the sequencer in MODIFY
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = alu_word;
        unique case (state_q)
            ST_IDLE: begin
                mem_addr  = req_addr;
                mem_wdata = req_opa;
                mem_en    = accept && (req_cls != CLS_BAD);
                mem_we    = accept && (req_cls == CLS_STORE);
            end
            ST_MODIFY: begin
                mem_en = alu_we;
                mem_we = alu_we;
            end
            default: ;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (req_cls == CLS_ATOMIC) ? ST_MODIFY : ST_RESP;
                end
            end
            ST_MODIFY: state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_LOAD;
            addr_q   <= '0;
            opa_q    <= '0;
            opb_q    <= '0;
            result_q <= '0;
            status_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (accept) begin
                op_q     <= req_op;
                addr_q   <= req_addr;
                opa_q    <= req_opa;
                opb_q    <= req_opb;
                result_q <= '0;
                status_q <= 1'b0;
                err_q    <= (req_cls == CLS_BAD);
            end else if (state_q == ST_MODIFY) begin
                result_q <= mem_rdata;
                status_q <= alu_cas_ok;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        rsp_valid  = (state_q == ST_RESP);
        rsp_data   = '0;
        rsp_status = 1'b0;
        rsp_err    = 1'b0;
        if (state_q == ST_RESP) begin
            rsp_data   = (op_q == OP_LOAD) ? mem_rdata : result_q;
            rsp_status = status_q;
            rsp_err    = err_q;
        end
    end
endmodule

// File: rtl/rmw_checker.sv
module rmw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] req_op,
    input logic       rsp_valid,
    input logic       rsp_status,
    input logic       rsp_err,
    input logic       mem_we
);
    logic take;
    assign take = req_valid && req_ready;

    a_r7_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op >= 3'd2 && req_op <= 3'd5) |=> !req_ready ##1 !req_ready);

    a_r7_atomic_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op >= 3'd2 && req_op <= 3'd5) |=> !rsp_valid ##1 rsp_valid);

    a_r2_plain_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op <= 3'd1) |=> rsp_valid);

    a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op >= 3'd6) |-> !mem_we);

    a_r8_err_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op >= 3'd6) |=> rsp_valid && rsp_err);

    a_r9_flags_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_status && !rsp_err));

    a_r10_closed_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r10_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);
endmodule

bind atomic_rmw_unit rmw_checker u_rmw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_err    (rsp_err),
    .mem_we     (mem_we)
);

// File: tb/tb_atomic_rmw_unit.sv
module tb_atomic_rmw_unit;
    localparam int DW = 32;
    localparam int DEPTH = 16;
    localparam int AW = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_opa = '0;
    logic [DW-1:0] req_opb = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          rsp_status;
    logic          rsp_err;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] r_data;
    logic          r_stat, r_err;
    int            r_lat, r_busy;

    always #10 clk = ~clk;

    atomic_rmw_unit #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_status(rsp_status),
        .rsp_err(rsp_err)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one request, collect its response, latency and busy count
    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] x, input logic [DW-1:0] y);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_opa = x; req_opb = y;
        r_lat = 0; r_busy = 0;
        @(negedge clk);
        req_valid = 1'b0;
        r_lat = 1;
        if (!req_ready) r_busy++;
        while (!rsp_valid && r_lat < 10) begin
            @(negedge clk);
            r_lat++;
            if (!req_ready) r_busy++;
        end
        r_data = rsp_data; r_stat = rsp_status; r_err = rsp_err;
        @(negedge clk);
        check("R10 ready after response", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic t_reset();
        check("R1 ready at reset", {31'd0, req_ready}, 32'd1);
        check("R1 no response at reset", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_load_store();
        issue(3'd1, 4'd3, 32'hCAFE_0001, '0);
        check("R2 store data", r_data, 32'd0);
        check("R2 store latency", r_lat, 1);
        issue(3'd0, 4'd3, '0, '0);
        check("R2 load data", r_data, 32'hCAFE_0001);
        check("R2 load latency", r_lat, 1);
        check("R9 load status", {31'd0, r_stat}, 32'd0);
        check("R9 load err", {31'd0, r_err}, 32'd0);
    endtask

    task automatic t_tas();
        issue(3'd1, 4'd5, 32'd0, '0);
        issue(3'd2, 4'd5, '0, '0);
        check("R3 tas old zero", r_data, 32'd0);
        check("R9 tas status", {31'd0, r_stat}, 32'd0);
        issue(3'd0, 4'd5, '0, '0);
        check("R3 tas wrote one", r_data, 32'd1);
        issue(3'd1, 4'd5, 32'd7, '0);
        issue(3'd2, 4'd5, '0, '0);
        check("R3 tas old nonzero", r_data, 32'd7);
        issue(3'd0, 4'd5, '0, '0);
        check("R3 tas left unchanged", r_data, 32'd7);
    endtask

    task automatic t_swap();
        issue(3'd1, 4'd6, 32'h1111, '0);
        issue(3'd3, 4'd6, 32'h2222, '0);
        check("R4 swap old", r_data, 32'h1111);
        check("R7 swap latency", r_lat, 2);
        check("R7 swap busy cycles", r_busy, 2);
        issue(3'd0, 4'd6, '0, '0);
        check("R4 swap new", r_data, 32'h2222);
    endtask

    task automatic t_fadd();
        issue(3'd1, 4'd7, 32'hFFFF_FFFF, '0);
        issue(3'd4, 4'd7, 32'd2, '0);
        check("R5 fadd old", r_data, 32'hFFFF_FFFF);
        issue(3'd0, 4'd7, '0, '0);
        check("R5 fadd wrap", r_data, 32'd1);
        for (int i = 0; i < 4; i++) begin
            issue(3'd4, 4'd7, 32'd10, '0);
            check("R10 fadd sequence", r_data, 32'd1 + 32'(10 * i));
        end
    endtask

    task automatic t_cas();
        issue(3'd1, 4'd9, 32'd50, '0);
        issue(3'd5, 4'd9, 32'd49, 32'd99);
        check("R6 cas fail old", r_data, 32'd50);
        check("R6 cas fail status", {31'd0, r_stat}, 32'd0);
        issue(3'd0, 4'd9, '0, '0);
        check("R6 cas fail unchanged", r_data, 32'd50);
        issue(3'd5, 4'd9, 32'd50, 32'd99);
        check("R6 cas ok old", r_data, 32'd50);
        check("R6 cas ok status", {31'd0, r_stat}, 32'd1);
        check("R7 cas latency", r_lat, 2);
        issue(3'd0, 4'd9, '0, '0);
        check("R6 cas ok written", r_data, 32'd99);
    endtask

    task automatic t_bad();
        issue(3'd1, 4'd12, 32'h5A5A, '0);
        for (int c = 6; c < 8; c++) begin
            issue(3'(c), 4'd12, 32'hDEAD, 32'hBEEF);
            check("R8 err flag", {31'd0, r_err}, 32'd1);
            check("R8 err data", r_data, 32'd0);
            check("R9 err status", {31'd0, r_stat}, 32'd0);
            issue(3'd0, 4'd12, '0, '0);
            check("R8 memory untouched", r_data, 32'h5A5A);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_store();
        t_tas();
        t_swap();
        t_fadd();
        t_cas();
        t_bad();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule